// File: doc/BRIEF.md
# Open-Drain Bus Driver with Arbitration-Loss Detection

This block sits between a serial-bus master sequencer and the two wired-AND lines of a shared two-wire bus (SDA and SCL). It drives both lines in open-drain fashion. Each line has a pull-down enable, and a high level is produced only by letting the external pull-up take the line. The sequencer supplies the bit it wants on SDA, a request to hold SCL low, and a flag that tells whether the current bits belong to the address stage or the data stage of a transfer.

The raw line levels pass through a configurable synchronizer. At every rising edge of SCL, as observed on the bus, the block checks whether SDA is low at a moment when it meant to leave SDA high. If so, another master has won the bus. The block then drops both pull-downs in the same clock edge that raises the loss flag, and it records which stage the loss happened in. Because the check waits for SCL to be seen high on the bus, a slave or rival master that stretches the clock delays the comparison rather than corrupting it.

The loss flag stays set until the sequencer pulses a clear input. While it is set, the block ignores drive requests and leaves both lines free. After that the sequencer may retry the transfer.

Top module: `i2c_arb_guard`

## Requirements
- R1: With `tx_en`=1 and no loss pending, `sda_oe` equals the inverse of `want_sda` one clock edge after the inputs are applied. `sda_oe`=1 means SDA is pulled low. The block never drives a line high.
- R2: With `tx_en`=1 and no loss pending, `scl_oe` equals `scl_low` one clock edge after the inputs are applied. `scl_oe`=1 means SCL is pulled low.
- R3: SDA is compared only while the block is transmitting and leaving SDA released (intended high). A bit that the block drives low is never flagged, even when SDA reads low at an SCL rise.
- R4: When an intended-high SDA reads low at an observed SCL rising edge, `arb_lost` rises and `sda_oe` and `scl_oe` both fall at the same clock edge. That edge is the (SYNC_STAGES+1)-th rising clock edge after `scl_in` goes high.
- R5: On a loss, `lost_in_address` takes the value of `in_addr` in the detecting cycle. The encoding is 1 for the address stage and 0 for the data stage.
- R6: `arb_lost` stays set until `arb_clear` is asserted. One edge after `arb_clear`, both `arb_lost` and `lost_in_address` read 0.
- R7: While `arb_lost` is set, changes on `tx_en`, `want_sda` and `scl_low` have no effect, and both drive enables stay 0.
- R8: A synchronous active-high `rst` clears `sda_oe`, `scl_oe`, `arb_lost` and `lost_in_address` at the next clock edge.
- R9: While SCL is held low by another device, no comparison takes place, whatever level SDA has. The comparison happens at the rise of SCL once SCL is released.
- R10: With `tx_en`=0, both drive enables are 0 and no loss is ever flagged, whatever activity appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Block is transmitting; enables both drivers |
| want_sda | input | 1 | Intended SDA level (1 = release, 0 = pull low) |
| scl_low | input | 1 | Request to pull SCL low |
| in_addr | input | 1 | Current stage: 1 = address, 0 = data |
| arb_clear | input | 1 | Clears the loss flag and the recorded stage |
| sda_in | input | 1 | Raw SDA level read from the bus |
| scl_in | input | 1 | Raw SCL level read from the bus |
| sda_oe | output | 1 | SDA pull-down enable |
| scl_oe | output | 1 | SCL pull-down enable |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| lost_in_address | output | 1 | Stage of the last loss: 1 = address, 0 = data |

## Verification
The assertions check several rules on every cycle. A detected loss releases both lines and sets the flag at the next edge, with the stage copied from `in_addr`. The flag holds until clear, and both lines stay free while it is set. Every rise of the flag traces back to a released SDA that read low. Reset leaves everything released.

Only the bench scenarios can show the rest, against a modelled wired-AND bus with a rival master. These are the exact latency from an SCL rise to the flag, that low bits are never flagged, that a stretched clock postpones the comparison, and that idle operation ignores bus traffic.

// File: rtl/i2carb_pkg.sv
package i2carb_pkg;

    // Transfer stage recorded on an arbitration loss
    typedef enum logic {
        PH_DATA = 1'b0,
        PH_ADDR = 1'b1
    } xfer_phase_e;

    // Sampled bus levels
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lvl_t;

    // Pull-down enables for the two lines
    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
    } drive_t;

    localparam bus_lvl_t BUS_IDLE = '{scl: 1'b1, sda: 1'b1};
    localparam drive_t   DRV_OFF  = '{scl_pull: 1'b0, sda_pull: 1'b0};

    // Pull-down pattern for the requested bits; nothing is pulled when blocked
    function automatic drive_t compute_drive(input logic en, input logic want_high,
                                             input logic hold_low, input logic blocked);
        drive_t d;
        d.sda_pull = en & ~blocked & ~want_high;
        d.scl_pull = en & ~blocked & hold_low;
        return d;
    endfunction

    function automatic xfer_phase_e phase_of(input logic addr_flag);
        return addr_flag ? PH_ADDR : PH_DATA;
    endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync
    import i2carb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_lvl_t raw,
    output bus_lvl_t synced
);
    localparam int LAST = STAGES - 1;

    bus_lvl_t chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= BUS_IDLE;
                else     chain[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= BUS_IDLE;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign synced = chain[LAST];

endmodule

// File: rtl/arb_monitor.sv
module arb_monitor
    import i2carb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_lvl_t    bus_s,
    input  logic        driving,
    input  logic        sda_pull,
    input  logic        in_addr,
    input  logic        arb_clear,
    output logic        loss_evt,
    output logic        hold_off,
    output logic        lost,
    output xfer_phase_e lost_phase
);
    logic scl_prev;
    logic scl_rise;
    logic lost_q;
    xfer_phase_e phase_q;

    assign scl_rise = bus_s.scl & ~scl_prev;
    // Compare only when released (intended high) and transmitting
    assign loss_evt = ~lost_q & driving & ~sda_pull & scl_rise & ~bus_s.sda;
    assign hold_off = loss_evt | (lost_q & ~arb_clear);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            lost_q   <= 1'b0;
            phase_q  <= PH_DATA;
        end else begin
            scl_prev <= bus_s.scl;
            if (loss_evt) begin
                lost_q  <= 1'b1;
                phase_q <= phase_of(in_addr);
            end else if (arb_clear) begin
                lost_q  <= 1'b0;
                phase_q <= PH_DATA;
            end
        end
    end

    assign lost       = lost_q;
    assign lost_phase = phase_q;

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        lost_q && !arb_clear |=> lost_q);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        lost_q && arb_clear |=> !lost_q && phase_q == PH_DATA);

    p_phase_r5: assert property (@(posedge clk) disable iff (rst)
        loss_evt |=> lost_q && phase_q == phase_of($past(in_addr)));

    p_high_only_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_q) |-> $past(driving && !sda_pull));

    p_bus_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_q) |-> $past(!bus_s.sda));

endmodule

// File: rtl/od_driver.sv
module od_driver
    import i2carb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic want_sda,
    input  logic scl_low,
    input  logic hold_off,
    output logic driving,
    output logic sda_oe,
    output logic scl_oe
);
    drive_t drv_d, drv_q;
    logic   act_q;

    assign drv_d = compute_drive(tx_en, want_sda, scl_low, hold_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= DRV_OFF;
            act_q <= 1'b0;
        end else begin
            drv_q <= drv_d;
            act_q <= tx_en & ~hold_off;
        end
    end

    assign driving = act_q;
    assign sda_oe  = drv_q.sda_pull;
    assign scl_oe  = drv_q.scl_pull;

    p_idle_free_r10: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !sda_oe && !scl_oe && !driving);

endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard
    import i2carb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic want_sda,
    input  logic scl_low,
    input  logic in_addr,
    input  logic arb_clear,
    input  logic sda_in,
    input  logic scl_in,
    output logic sda_oe,
    output logic scl_oe,
    output logic arb_lost,
    output logic lost_in_address
);
    bus_lvl_t    raw_lvl, sync_lvl;
    logic        loss_evt, hold_off, driving;
    xfer_phase_e lost_phase;

    assign raw_lvl = '{scl: scl_in, sda: sda_in};

    bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_lvl),
        .synced (sync_lvl)
    );

    arb_monitor u_mon (
        .clk        (clk),
        .rst        (rst),
        .bus_s      (sync_lvl),
        .driving    (driving),
        .sda_pull   (sda_oe),
        .in_addr    (in_addr),
        .arb_clear  (arb_clear),
        .loss_evt   (loss_evt),
        .hold_off   (hold_off),
        .lost       (arb_lost),
        .lost_phase (lost_phase)
    );

    od_driver u_drv (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .want_sda (want_sda),
        .scl_low  (scl_low),
        .hold_off (hold_off),
        .driving  (driving),
        .sda_oe   (sda_oe),
        .scl_oe   (scl_oe)
    );

    assign lost_in_address = (lost_phase == PH_ADDR);

    p_release_on_loss_r4: assert property (@(posedge clk) disable iff (rst)
        loss_evt |=> arb_lost && !sda_oe && !scl_oe);

    p_lines_free_r7: assert property (@(posedge clk) disable iff (rst)
        arb_lost |-> !sda_oe && !scl_oe);

    p_reset_release_r8: assert property (@(posedge clk)
        rst |=> !sda_oe && !scl_oe && !arb_lost && !lost_in_address);

endmodule

// File: tb/sim_i2c_arb_guard.sv
module sim_i2c_arb_guard;
    logic clk = 1'b0;
    logic rst, tx_en, want_sda, scl_low, in_addr, arb_clear;
    logic rival_sda, rival_scl;
    logic sda_in, scl_in, sda_oe, scl_oe, arb_lost, lost_in_address;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // Wired-AND bus with a rival master
    assign sda_in = ~(sda_oe | rival_sda);
    assign scl_in = ~(scl_oe | rival_scl);

    i2c_arb_guard #(.SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .want_sda(want_sda),
        .scl_low(scl_low), .in_addr(in_addr), .arb_clear(arb_clear),
        .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .arb_lost(arb_lost), .lost_in_address(lost_in_address)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_loss();
        arb_clear = 1'b1; cyc(1); arb_clear = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cyc(2);
        chk("R8 sda_oe", sda_oe, 1'b0);
        chk("R8 scl_oe", scl_oe, 1'b0);
        chk("R8 arb_lost", arb_lost, 1'b0);
        chk("R8 lost_in_address", lost_in_address, 1'b0);
        rst = 1'b0; cyc(1);
    endtask

    task automatic t_drive();
        tx_en = 1'b1; want_sda = 1'b0; scl_low = 1'b1; cyc(1);
        chk("R1 sda pulled for 0", sda_oe, 1'b1);
        chk("R2 scl pulled", scl_oe, 1'b1);
        want_sda = 1'b1; cyc(1);
        chk("R1 sda released for 1", sda_oe, 1'b0);
        scl_low = 1'b0; cyc(1);
        chk("R2 scl released", scl_oe, 1'b0);
        scl_low = 1'b1; cyc(4);
    endtask

    task automatic t_low_unchecked();
        // We drive 0 while the rival also pulls SDA low; SCL pulses
        tx_en = 1'b1; want_sda = 1'b0; rival_sda = 1'b1; scl_low = 1'b1; cyc(4);
        for (int k = 0; k < 3; k++) begin
            scl_low = 1'b0; cyc(6); scl_low = 1'b1; cyc(6);
        end
        chk("R3 low bit not flagged", arb_lost, 1'b0);
        rival_sda = 1'b0;
        want_sda = 1'b1; scl_low = 1'b0; cyc(8);
        chk("R3 matching high bit not flagged", arb_lost, 1'b0);
        scl_low = 1'b1; cyc(4);
    endtask

    task automatic t_loss(input logic addr);
        tx_en = 1'b1; want_sda = 1'b1; scl_low = 1'b1; in_addr = addr; cyc(4);
        rival_sda = 1'b1;
        scl_low = 1'b0;               // edge 1: scl_oe drops, scl_in rises
        cyc(3);                       // edges 2,3 through the synchronizer
        chk("R4 no flag before latency", arb_lost, 1'b0);
        cyc(1);                       // edge 4 = SYNC_STAGES+1 after scl_in rise
        chk("R4 arb_lost set", arb_lost, 1'b1);
        chk("R4 sda released", sda_oe, 1'b0);
        chk("R4 scl released", scl_oe, 1'b0);
        chk("R5 stage recorded", lost_in_address, addr);
        rival_sda = 1'b0;
    endtask

    task automatic t_sticky();
        // Requests while lost are ignored
        want_sda = 1'b0; scl_low = 1'b1; tx_en = 1'b1; cyc(3);
        chk("R7 sda stays free", sda_oe, 1'b0);
        chk("R7 scl stays free", scl_oe, 1'b0);
        chk("R6 flag held", arb_lost, 1'b1);
        want_sda = 1'b1; scl_low = 1'b0; cyc(2);
        chk("R7 still free", scl_oe | sda_oe, 1'b0);
        clear_loss();
        chk("R6 cleared", arb_lost, 1'b0);
        chk("R6 stage cleared", lost_in_address, 1'b0);
        scl_low = 1'b1; want_sda = 1'b0; cyc(1);
        chk("R1 driving resumes after clear", sda_oe, 1'b1);
        chk("R2 driving resumes after clear", scl_oe, 1'b1);
    endtask

    task automatic t_stretch();
        want_sda = 1'b1; scl_low = 1'b1; in_addr = 1'b0; cyc(3);
        rival_scl = 1'b1; rival_sda = 1'b1;
        scl_low = 1'b0; cyc(10);
        chk("R9 no compare while stretched", arb_lost, 1'b0);
        rival_scl = 1'b0;             // scl_in rises now (mid-cycle)
        cyc(2);
        chk("R9 not yet after release", arb_lost, 1'b0);
        cyc(1);
        chk("R9 compare at released rise", arb_lost, 1'b1);
        chk("R5 data stage", lost_in_address, 1'b0);
        rival_sda = 1'b0;
        clear_loss();
    endtask

    task automatic t_idle();
        tx_en = 1'b0; want_sda = 1'b1; scl_low = 1'b0; cyc(2);
        chk("R10 sda free idle", sda_oe, 1'b0);
        chk("R10 scl free idle", scl_oe, 1'b0);
        rival_sda = 1'b1;
        for (int k = 0; k < 3; k++) begin
            rival_scl = 1'b1; cyc(5); rival_scl = 1'b0; cyc(5);
        end
        chk("R10 no flag idle", arb_lost, 1'b0);
        rival_sda = 1'b0;
    endtask

    initial begin
        rst = 1'b1; tx_en = 1'b0; want_sda = 1'b1; scl_low = 1'b0;
        in_addr = 1'b0; arb_clear = 1'b0; rival_sda = 1'b0; rival_scl = 1'b0;
        cyc(1);
        t_reset();
        t_drive();
        t_low_unchecked();
        t_loss(1'b0);
        t_sticky();
        t_loss(1'b1);
        clear_loss();
        t_stretch();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule